// File: doc/BRIEF.md
# Memory Controller Event Counter Unit

This block counts activity inside a memory controller on behalf of software. It holds up to four general event counters and an optional free-running cycle counter, all 64 bits wide. Each general counter is tied to one line of an event strobe vector by a programmable event number. Software reaches every counter as two 32-bit words through a simple single-cycle register bus. It turns counters and interrupts on and off through separate write-one-to-set and write-one-to-clear registers, and it polls or clears overflow status. A single level interrupt goes high while any overflow bit with its interrupt enabled is set.

A small access state machine tracks read responses. It has two states. `ST_IDLE` means no read data is pending. `ST_RESP` means read data is being presented. A read request in either state leads to `ST_RESP` (transitions IDLE_TO_RESP and RESP_HOLD). Any other cycle leads to `ST_IDLE` (transitions RESP_TO_IDLE and IDLE_HOLD). Read data is registered and appears on the cycle after the request.

Three filter words (threshold, rank, bank) are stored for software. No filtering logic sits behind them. A configuration word and an identity word are fixed constants.

Top module: `pmu_event_unit`

## Requirements
- R1: After reset every counter, enable mask, overflow bit and filter word is zero, `irq` is 0 and `bus_rvalid` is 0.
- R2: General counter n has its low word at offset 8*n and its high word at 8*n+4. The cycle counter has its low word at 0x0F8 and its high word at 0x0FC. All of these words are writable and read back what was written.
- R3: The event select for counter n sits at 0x400+4*n and keeps 9 bits. An enabled counter adds one on each cycle in which strobe `evt_strobe[sel]` is high. A select value of `NUM_EVT` or above never counts.
- R4: Writing ones to 0xC00 sets counter-enable bits and writing ones to 0xC20 clears them. Both offsets read the current mask. Bits 0..NUM_CTR-1 map to the general counters and bit 31 maps to the cycle counter. The cycle counter adds one on every cycle while it is enabled.
- R5: Bit 0 of the control word at 0xE04 is the global enable. While it is 0, no counter changes except through a bus write.
- R6: Writing 1 to bit 1 of 0xE04 zeroes all general counters in that cycle. Bit 1 always reads back as 0.
- R7: When a counter steps from all ones to zero, its overflow bit is set. The overflow status is read at 0xCC0. Writing ones to 0xC80 clears the matching bits.
- R8: Interrupt-enable set is at 0xC40 and clear is at 0xC60, with the same bit layout and read-back as R4. `irq` is high exactly when some overflow bit has its interrupt enable set.
- R9: 0xE00 reads NUM_CTR in bits 3:0 and the presence of the cycle counter in bit 14. 0xFBC reads the constant `DEV_ID`.
- R10: The filter words at 0xD80, 0xD84 and 0xD88 are 32-bit read/write registers.
- R11: A carry out of the low word is visible in the high word of the same counter on the next read.
- R12: A bus write to a counter word in a cycle where that counter also counts takes priority over the increment.
- R13: An offset with no register reads as zero, and writes to it have no effect.
- R14: Read data appears on `bus_rdata` with `bus_rvalid` high on the cycle after a read request. `bus_rvalid` is low after any cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| evt_strobe | input | NUM_EVT | One pulse per cycle per event, indexed by event number |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties check the following on every cycle:
- the single-step increment, with write and reset-command priority over it;
- wrap to zero, and the overflow bit it sets;
- the stability of counters while the global enable is low;
- the enable masks staying within their valid bits;
- the read-valid timing of the access state machine.

Only the bench scenarios can show:
- the address map;
- the mapping of event selects to strobe lines;
- rejection of out-of-range selects;
- carry visibility across the two words;
- the masking of the interrupt by its enable, which needs whole sequences of bus traffic with expected read values.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam logic [11:0] OFF_CYC_LO  = 12'h0F8;
    localparam logic [11:0] OFF_CYC_HI  = 12'h0FC;
    localparam logic [3:0]  PAGE_CTR    = 4'h0;
    localparam logic [3:0]  PAGE_EVSEL  = 4'h4;
    localparam logic [11:0] OFF_CEN_SET = 12'hC00;
    localparam logic [11:0] OFF_CEN_CLR = 12'hC20;
    localparam logic [11:0] OFF_IEN_SET = 12'hC40;
    localparam logic [11:0] OFF_IEN_CLR = 12'hC60;
    localparam logic [11:0] OFF_OVF_CLR = 12'hC80;
    localparam logic [11:0] OFF_OVF_STS = 12'hCC0;
    localparam logic [11:0] OFF_FLT_THR = 12'hD80;
    localparam logic [11:0] OFF_FLT_RNK = 12'hD84;
    localparam logic [11:0] OFF_FLT_BNK = 12'hD88;
    localparam logic [11:0] OFF_CONFIG  = 12'hE00;
    localparam logic [11:0] OFF_CONTROL = 12'hE04;
    localparam logic [11:0] OFF_IDENT   = 12'hFBC;

    localparam int CYC_BIT     = 31;
    localparam int CFG_CYC_BIT = 14;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_t;

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [31:0]   wdata,
    output logic [CW-1:0] value,
    output logic          wrap
);
    localparam int HW = CW / 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (wr_lo) begin
            value[HW-1:0] <= wdata[HW-1:0];
        end else if (wr_hi) begin
            value[CW-1:HW] <= wdata[HW-1:0];
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end

    always_comb begin
        wrap = inc && !clr && !wr_lo && !wr_hi && (&value);
    end

    // R3 / R11: an uninterrupted increment adds exactly one across both words
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !wr_lo && !wr_hi) |=> value == $past(value) + 1'b1);

    // R12: a bus write wins over a coincident increment
    a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !clr) |=> value[HW-1:0] == $past(wdata[HW-1:0]));

    // R6: reset command zeroes the counter
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> value == '0);

    // R7: a wrap lands on zero
    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> value == '0);

endmodule

// File: rtl/pmu_bus_fsm.sv
module pmu_bus_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we,
    output logic rvalid
);
    import pmu_pkg::*;

    bus_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = (req && !we) ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = (req && !we) ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        rvalid = (state == ST_RESP);
    end

    // R14: a read request yields valid data on the next cycle
    a_r14_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);

    // R14: no request, no valid on the next cycle
    a_r14_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> !rvalid);

endmodule

// File: rtl/pmu_event_unit.sv
module pmu_event_unit #(
    parameter int          NUM_CTR = 4,
    parameter int          NUM_EVT = 64,
    parameter int          EVT_W   = 9,
    parameter bit          HAS_CYC = 1'b1,
    parameter logic [31:0] DEV_ID  = 32'h0001_0A5C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic               irq
);
    import pmu_pkg::*;

    localparam int CW = 64;
    localparam logic [31:0] GEN_MASK   = 32'((64'd1 << NUM_CTR) - 64'd1);
    localparam logic [31:0] VALID_MASK = GEN_MASK | (32'(HAS_CYC) << CYC_BIT);
    localparam logic [31:0] CFG_WORD   = 32'(NUM_CTR) | (32'(HAS_CYC) << CFG_CYC_BIT);

    // ------------------------------------------------------------------
    // Bus decode
    // ------------------------------------------------------------------
    logic       wr_en, rd_en;
    logic [4:0] ctr_idx;
    logic       ctr_hi, in_ctr_page, in_sel_page;
    logic [5:0] sel_idx;

    always_comb begin
        wr_en       = bus_req && bus_we;
        rd_en       = bus_req && !bus_we;
        ctr_idx     = bus_addr[7:3];
        ctr_hi      = bus_addr[2];
        in_ctr_page = (bus_addr[11:8] == PAGE_CTR) && (int'(ctr_idx) < NUM_CTR);
        in_sel_page = (bus_addr[11:8] == PAGE_EVSEL) && (bus_addr[1:0] == 2'b00)
                      && (int'(bus_addr[7:2]) < NUM_CTR);
        sel_idx     = bus_addr[7:2];
    end

    // ------------------------------------------------------------------
    // Control, masks, filters, event selects
    // ------------------------------------------------------------------
    logic             glob_en;
    logic             reset_cmd;
    logic [31:0]      cen, ien, ovf;
    logic [31:0]      flt_thr, flt_rnk, flt_bnk;
    logic [EVT_W-1:0] evsel [NUM_CTR];
    logic [31:0]      wrap_vec;

    always_comb begin
        reset_cmd = wr_en && (bus_addr == OFF_CONTROL) && bus_wdata[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
            cen     <= '0;
            ien     <= '0;
            flt_thr <= '0;
            flt_rnk <= '0;
            flt_bnk <= '0;
        end else if (wr_en) begin
            unique case (bus_addr)
                OFF_CONTROL: glob_en <= bus_wdata[0];
                OFF_CEN_SET: cen     <= cen | (bus_wdata & VALID_MASK);
                OFF_CEN_CLR: cen     <= cen & ~bus_wdata;
                OFF_IEN_SET: ien     <= ien | (bus_wdata & VALID_MASK);
                OFF_IEN_CLR: ien     <= ien & ~bus_wdata;
                OFF_FLT_THR: flt_thr <= bus_wdata;
                OFF_FLT_RNK: flt_rnk <= bus_wdata;
                OFF_FLT_BNK: flt_bnk <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= '0;
        end else begin
            ovf <= ((wr_en && bus_addr == OFF_OVF_CLR) ? (ovf & ~bus_wdata) : ovf)
                   | wrap_vec;
        end
    end

    always_comb begin
        irq = |(ovf & ien);
    end

    // ------------------------------------------------------------------
    // General counters
    // ------------------------------------------------------------------
    logic [CW-1:0]      ctr_val [NUM_CTR];
    logic [NUM_CTR-1:0] ctr_wrap;
    logic [NUM_CTR-1:0] ctr_inc;
    logic [NUM_CTR-1:0] ctr_wlo, ctr_whi;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evsel[i] <= '0;
            end else if (wr_en && in_sel_page && int'(sel_idx) == i) begin
                evsel[i] <= bus_wdata[EVT_W-1:0];
            end
        end

        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int e = 0; e < NUM_EVT; e++) begin
                if (evsel[i] == EVT_W'(e)) hit = evt_strobe[e];
            end
            ctr_inc[i] = glob_en && cen[i] && hit;
            ctr_wlo[i] = wr_en && in_ctr_page && int'(ctr_idx) == i && !ctr_hi;
            ctr_whi[i] = wr_en && in_ctr_page && int'(ctr_idx) == i && ctr_hi;
        end

        pmu_counter #(.CW(CW)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ctr_inc[i]),
            .clr   (reset_cmd),
            .wr_lo (ctr_wlo[i]),
            .wr_hi (ctr_whi[i]),
            .wdata (bus_wdata),
            .value (ctr_val[i]),
            .wrap  (ctr_wrap[i])
        );

        // R5: with global enable low and no bus write or reset, the counter holds
        a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!glob_en && !ctr_wlo[i] && !ctr_whi[i] && !reset_cmd)
            |=> $stable(ctr_val[i]));

        // R7: a wrap raises the matching overflow bit
        a_r7_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
            ctr_wrap[i] |=> ovf[i]);
    end

    // ------------------------------------------------------------------
    // Cycle counter
    // ------------------------------------------------------------------
    logic [CW-1:0] cyc_val;
    logic          cyc_wrap;

    if (HAS_CYC) begin : g_cyc
        logic cyc_inc, cyc_wlo, cyc_whi;
        always_comb begin
            cyc_inc = glob_en && cen[CYC_BIT];
            cyc_wlo = wr_en && (bus_addr == OFF_CYC_LO);
            cyc_whi = wr_en && (bus_addr == OFF_CYC_HI);
        end
        pmu_counter #(.CW(CW)) u_cyc (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cyc_inc),
            .clr   (1'b0),
            .wr_lo (cyc_wlo),
            .wr_hi (cyc_whi),
            .wdata (bus_wdata),
            .value (cyc_val),
            .wrap  (cyc_wrap)
        );
    end else begin : g_no_cyc
        always_comb begin
            cyc_val  = '0;
            cyc_wrap = 1'b0;
        end
    end

    always_comb begin
        wrap_vec = '0;
        wrap_vec[NUM_CTR-1:0] = ctr_wrap;
        wrap_vec[CYC_BIT] = cyc_wrap;
    end

    // ------------------------------------------------------------------
    // Read path
    // ------------------------------------------------------------------
    logic [31:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (in_ctr_page) begin
            rd_mux = ctr_hi ? ctr_val[ctr_idx][63:32] : ctr_val[ctr_idx][31:0];
        end else if (in_sel_page) begin
            rd_mux = 32'(evsel[sel_idx]);
        end else begin
            unique case (bus_addr)
                OFF_CYC_LO:  rd_mux = cyc_val[31:0];
                OFF_CYC_HI:  rd_mux = cyc_val[63:32];
                OFF_CEN_SET,
                OFF_CEN_CLR: rd_mux = cen;
                OFF_IEN_SET,
                OFF_IEN_CLR: rd_mux = ien;
                OFF_OVF_STS: rd_mux = ovf;
                OFF_FLT_THR: rd_mux = flt_thr;
                OFF_FLT_RNK: rd_mux = flt_rnk;
                OFF_FLT_BNK: rd_mux = flt_bnk;
                OFF_CONFIG:  rd_mux = CFG_WORD;
                OFF_CONTROL: rd_mux = {31'd0, glob_en};
                OFF_IDENT:   rd_mux = DEV_ID;
                default:     rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux;
    end

    pmu_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .we     (bus_we),
        .rvalid (bus_rvalid)
    );

    // R4 / R8: masks never hold bits outside the implemented counters
    a_r4_mask_range: assert property (@(posedge clk) disable iff (!rst_n)
        ((cen | ien) & ~VALID_MASK) == '0);

    // R8: no interrupt without some interrupt enable
    a_r8_irq_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    // R7: a clear write with no new wrap removes the bits it names
    a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFF_OVF_CLR && wrap_vec == '0)
        |=> (ovf & $past(bus_wdata)) == '0);

endmodule

// File: tb/pmu_event_unit_test.sv
module pmu_event_unit_test;

    localparam int NUM_EVT = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_req = 1'b0;
    logic               bus_we = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               bus_rvalid;
    logic [NUM_EVT-1:0] evt_strobe = '0;
    logic               irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pmu_event_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .evt_strobe (evt_strobe),
        .irq        (irq)
    );

    // {write, addr, data, expected read}
    localparam int NV = 27;
    localparam logic [76:0] VEC [NV] = '{
        {1'b1, 12'h008, 32'hDEADBEEF, 32'h0},          // R2
        {1'b0, 12'h008, 32'h0,        32'hDEADBEEF},
        {1'b1, 12'h00C, 32'h12345678, 32'h0},
        {1'b0, 12'h00C, 32'h0,        32'h12345678},
        {1'b1, 12'h0FC, 32'h000000AB, 32'h0},
        {1'b0, 12'h0FC, 32'h0,        32'h000000AB},
        {1'b1, 12'h404, 32'hFFFFFFFF, 32'h0},          // R3 width
        {1'b0, 12'h404, 32'h0,        32'h000001FF},
        {1'b1, 12'hC00, 32'hFFFFFFFF, 32'h0},          // R4
        {1'b0, 12'hC00, 32'h0,        32'h8000000F},
        {1'b0, 12'hC20, 32'h0,        32'h8000000F},
        {1'b1, 12'hC20, 32'h00000005, 32'h0},
        {1'b0, 12'hC00, 32'h0,        32'h8000000A},
        {1'b1, 12'hC20, 32'hFFFFFFFF, 32'h0},
        {1'b0, 12'hC00, 32'h0,        32'h0},
        {1'b1, 12'hC40, 32'h80000001, 32'h0},          // R8
        {1'b0, 12'hC60, 32'h0,        32'h80000001},
        {1'b1, 12'hC60, 32'hFFFFFFFF, 32'h0},
        {1'b0, 12'hE00, 32'h0,        32'h00004004},   // R9
        {1'b0, 12'hFBC, 32'h0,        32'h00010A5C},
        {1'b1, 12'hD80, 32'h000000AA, 32'h0},          // R10
        {1'b0, 12'hD80, 32'h0,        32'h000000AA},
        {1'b1, 12'hD88, 32'hCAFEF00D, 32'h0},
        {1'b0, 12'hD88, 32'h0,        32'hCAFEF00D},
        {1'b0, 12'hD84, 32'h0,        32'h0},
        {1'b1, 12'h900, 32'hFFFFFFFF, 32'h0},          // R13
        {1'b0, 12'h900, 32'h0,        32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 rvalid", 32'(bus_rvalid), 32'h0);
        rd(12'h000, v); chk("R1 ctr0", v, 32'h0);
        rd(12'hCC0, v); chk("R1 ovf", v, 32'h0);
        // R14 valid timing
        chk("R14 rvalid after read", 32'(bus_rvalid), 32'h1);
        wr(12'h900, 32'h0);
        chk("R14 rvalid after write", 32'(bus_rvalid), 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][75:64], v);
                chk($sformatf("R2/R3/R4/R8/R9/R10/R13 vec %0d", i), v, VEC[i][31:0]);
            end
        end

        // R3 counting
        wr(12'h400, 32'd5); wr(12'hC00, 32'h1); wr(12'hE04, 32'h1);
        evt_strobe[5] = 1'b1;
        repeat (3) @(negedge clk);
        evt_strobe[5] = 1'b0;
        rd(12'h000, v); chk("R3 count", v, 32'd3);

        // R4 cycle counter
        wr(12'hC00, 32'h80000000);
        rd(12'h0F8, a); rd(12'h0F8, b);
        chk("R4 cycle step", b - a, 32'd1);

        // R5 global enable off
        wr(12'hE04, 32'h0);
        rd(12'h0F8, a);
        evt_strobe[5] = 1'b1;
        repeat (3) @(negedge clk);
        evt_strobe[5] = 1'b0;
        rd(12'h000, v); chk("R5 ctr0 frozen", v, 32'd3);
        rd(12'h0F8, v); chk("R5 cycle frozen", v, a);

        // R3 out-of-range select
        wr(12'h404, 32'd100); wr(12'hC00, 32'h2); wr(12'hE04, 32'h1);
        evt_strobe = '1;
        repeat (2) @(negedge clk);
        evt_strobe = '0;
        rd(12'h008, v); chk("R3 unconnected event", v, 32'hDEADBEEF);
        rd(12'h000, v); chk("R3 ctr0 counted", v, 32'd5);

        // R7 / R8 wrap, overflow, interrupt
        wr(12'hE04, 32'h0);
        wr(12'h010, 32'hFFFFFFFF); wr(12'h014, 32'hFFFFFFFF);
        wr(12'h408, 32'd0); wr(12'hC00, 32'h4); wr(12'hC40, 32'h4);
        wr(12'hE04, 32'h1);
        chk("R8 irq before wrap", 32'(irq), 32'h0);
        evt_strobe[0] = 1'b1;
        @(negedge clk);
        evt_strobe[0] = 1'b0;
        chk("R8 irq after wrap", 32'(irq), 32'h1);
        rd(12'h010, v); chk("R7 wrapped low", v, 32'h0);
        rd(12'h014, v); chk("R7 wrapped high", v, 32'h0);
        rd(12'hCC0, v); chk("R7 ovf status", v, 32'h4);
        wr(12'hC60, 32'h4);
        chk("R8 irq masked", 32'(irq), 32'h0);
        rd(12'hCC0, v); chk("R8 ovf kept", v, 32'h4);
        wr(12'hC80, 32'h4);
        rd(12'hCC0, v); chk("R7 ovf cleared", v, 32'h0);

        // R11 carry into high word
        wr(12'hE04, 32'h0);
        wr(12'h018, 32'hFFFFFFFF); wr(12'h01C, 32'h0);
        wr(12'h40C, 32'd1); wr(12'hC00, 32'h8); wr(12'hE04, 32'h1);
        evt_strobe[1] = 1'b1;
        @(negedge clk);
        evt_strobe[1] = 1'b0;
        rd(12'h01C, v); chk("R11 high carry", v, 32'h1);
        rd(12'h018, v); chk("R11 low zero", v, 32'h0);

        // R12 write beats increment
        evt_strobe[5] = 1'b1;
        wr(12'h000, 32'h100);
        evt_strobe[5] = 1'b0;
        rd(12'h000, v); chk("R12 write priority", v, 32'h100);

        // R6 reset command
        wr(12'hE04, 32'h3);
        rd(12'h000, v); chk("R6 ctr0 zero", v, 32'h0);
        rd(12'h008, v); chk("R6 ctr1 zero", v, 32'h0);
        rd(12'h01C, v); chk("R6 ctr3 high zero", v, 32'h0);
        rd(12'hE04, v); chk("R6 bit1 reads 0", v, 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule